// File: doc/BRIEF.md
# AUX channel request engine

This block turns one command from a display controller into a DisplayPort AUX request. It handles native reads and writes and I2C-over-AUX transfers, and it judges the reply that comes back. A command is the operation, a 16-bit address, a byte count and up to 16 bytes of write data. For each attempt the engine streams a four-byte request header to a lower-level AUX serializer over a valid/ready byte interface, followed by any payload bytes. It then waits for that serializer to return one reply bundle, which holds the line status, the reply code byte, a received byte count and the received data.

The engine decides from the reply whether to finish, retry at once or retry after a defer pause. All retries, whatever their cause, draw on one shared budget of attempts. The defer pause is a cycle count derived from the clock frequency parameter. When the engine finishes it raises a single-cycle done pulse together with an encoded status, the clamped received byte count and the received data.

Top module: `aux_req_engine`

## Requirements
- R1: Header byte 0 is address[7:0] and byte 1 is address[15:8]. Byte 2 carries the command in bits [7:4]: native write 8, native read 9, I2C write 0, I2C read 1, I2C address-only 0. Byte 3 is {total request length[3:0], (len-1)[3:0]} for native operations, where the total is 4+len for writes and 4 for reads. I2C write sends 5 bytes with byte 3 = 0x50, and I2C read sends 4 bytes with byte 3 = 0x40. Payload byte k is wdata_i[8k+7:8k] and follows the header.
- R2: For I2C operations (op_i 2, 3 and 4) with i2c_stop_i low, bit 6 of header byte 2 is set. With i2c_stop_i high it is clear. Native commands never set it.
- R3: An I2C address-only request (op_i = 4) is exactly 4 bytes long, uses the write command, and has byte 3 = 0x30.
- R4: A native request (op_i 0 or 1) with len_i = 0 or len_i > 16 sends no byte. It raises done_o one cycle after start_i, with status io_error.
- R5: Line status 1 ends the request with timeout, and line status 3 ends it with io_error. Neither is retried.
- R6: Line status 2 (busy) retries with no pause: the next request's first byte is offered on the cycle after the reply.
- R7: A native reply field (code bits [5:4]) of 2, or for I2C operations an I2C reply field (bits [7:6]) of 2 under a native field of 0, is a defer. The engine offers no byte for at least CLK_HZ/1e6*DEFER_US cycles and then resends the request.
- R8: At most MAX_TRIES (4) attempts are made in total, counting busy and defer retries alike. A retry outcome on the last attempt ends the request with io_error.
- R9: For native operations, field value 1 is nack and 3 is invalid. A native read whose non-ACK, non-defer reply carries zero data bytes ends with protocol_error instead. For I2C operations the I2C field is ignored unless the native field is 0.
- R10: For I2C operations, a native field of 1 or an I2C field of 1 ends with nack. A field value of 3 ends with invalid. Native and I2C fields both 0 ends with ok.
- R11: On ok, rcv_len_o = min(rx_len_i, len_i) for native reads, min(rx_len_i, 1) for I2C reads, and 0 otherwise. rcv_len_o is 0 on any error. Bytes of rdata_o at or beyond rcv_len_o read as zero, and byte k below it equals received byte k.
- R12: done_o is a single-cycle pulse. status_o encodes ok=0, timeout=1, nack=2, io_error=3, protocol_error=4, invalid=5. After reset done_o and tx_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle launch pulse, sampled while idle |
| op_i | input | 3 | 0 native write, 1 native read, 2 I2C write, 3 I2C read, 4 I2C address-only |
| i2c_stop_i | input | 1 | I2C request ends the transaction |
| addr_i | input | 16 | Target address |
| len_i | input | 5 | Native payload bytes / read buffer size |
| wdata_i | input | 128 | Write payload, byte k at [8k+7:8k] |
| tx_valid_o | output | 1 | Request byte valid |
| tx_ready_i | input | 1 | Serializer accepts byte |
| tx_data_o | output | 8 | Request byte |
| tx_last_o | output | 1 | Final byte of this attempt |
| rx_valid_i | input | 1 | Reply bundle valid (one cycle) |
| rx_phy_st_i | input | 2 | Line status: 0 reply, 1 timeout, 2 busy, 3 error |
| rx_code_i | input | 8 | Reply code byte |
| rx_len_i | input | 5 | Received data byte count |
| rx_data_i | input | 128 | Received data |
| done_o | output | 1 | Completion pulse |
| status_o | output | 3 | Completion status |
| rcv_len_o | output | 5 | Clamped received byte count |
| rdata_o | output | 128 | Received data, masked beyond rcv_len_o |

## Verification
The hardest situation to reach from the ports is the end of the shared attempt budget after a mix of busy and defer outcomes. At that point the engine must stop on a retry outcome rather than resend. The bench's serializer model replays a per-request script of four replies. Mixing busy, native-defer and I2C-defer codes drives the engine through every retry path into the exhausted case. The model also times the gap before each resend, which separates an immediate retry from a paused one.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
  typedef enum logic [2:0] {
    OP_NAT_WR   = 3'd0,
    OP_NAT_RD   = 3'd1,
    OP_I2C_WR   = 3'd2,
    OP_I2C_RD   = 3'd3,
    OP_I2C_ADDR = 3'd4
  } aux_op_e;

  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_TIMEOUT   = 3'd1,
    ST_NACK      = 3'd2,
    ST_IO_ERR    = 3'd3,
    ST_PROTO_ERR = 3'd4,
    ST_INVALID   = 3'd5
  } aux_status_e;

  typedef enum logic [1:0] {
    ACT_FINISH,
    ACT_RETRY_NOW,
    ACT_RETRY_WAIT
  } aux_act_e;

  localparam logic [1:0] PHY_REPLY   = 2'd0;
  localparam logic [1:0] PHY_TIMEOUT = 2'd1;
  localparam logic [1:0] PHY_BUSY    = 2'd2;
  localparam logic [1:0] PHY_ERROR   = 2'd3;

  localparam logic [1:0] RPL_ACK   = 2'd0;
  localparam logic [1:0] RPL_NACK  = 2'd1;
  localparam logic [1:0] RPL_DEFER = 2'd2;

  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;
  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT    = 4'h4;
endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build
  import aux_req_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  localparam int LENW = $clog2(MAX_BYTES + 1),
  localparam int LW   = $clog2(MAX_BYTES + 5),
  localparam int IW   = $clog2(MAX_BYTES)
) (
  input  aux_op_e                  op_i,
  input  logic                     stop_i,
  input  logic [15:0]              addr_i,
  input  logic [LENW-1:0]          len_i,
  input  logic [MAX_BYTES*8-1:0]   wdata_i,
  input  logic [LW-1:0]            idx_i,
  output logic [7:0]               byte_o,
  output logic [LW-1:0]            nbytes_o
);
  logic [3:0]    cmd;
  logic [7:0]    len_byte;
  logic [LW-1:0] pay;
  logic [IW-1:0] widx;
  logic          is_i2c;

  assign is_i2c = (op_i == OP_I2C_WR) || (op_i == OP_I2C_RD) || (op_i == OP_I2C_ADDR);

  always_comb begin
    unique case (op_i)
      OP_NAT_WR: begin cmd = CMD_NAT_WR; pay = LW'(len_i); end
      OP_NAT_RD: begin cmd = CMD_NAT_RD; pay = '0; end
      OP_I2C_WR: begin cmd = CMD_I2C_WR; pay = LW'(1); end
      OP_I2C_RD: begin cmd = CMD_I2C_RD; pay = '0; end
      default:   begin cmd = CMD_I2C_WR; pay = '0; end
    endcase
    // middle-of-transaction flag for I2C requests that do not stop
    if (is_i2c && !stop_i) cmd = cmd | CMD_MOT;
  end

  assign nbytes_o = LW'(4) + pay;

  always_comb begin
    if (!is_i2c)                 len_byte = {nbytes_o[3:0], len_i[3:0] - 4'd1};
    else if (op_i == OP_I2C_ADDR) len_byte = 8'h30;
    else                         len_byte = {nbytes_o[3:0], 4'h0};
  end

  assign widx = IW'(idx_i - LW'(4));

  always_comb begin
    case (idx_i)
      LW'(0):  byte_o = addr_i[7:0];
      LW'(1):  byte_o = addr_i[15:8];
      LW'(2):  byte_o = {cmd, 4'h0};
      LW'(3):  byte_o = len_byte;
      default: byte_o = wdata_i[{widx, 3'b000} +: 8];
    endcase
  end
endmodule

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
  import aux_req_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  localparam int LENW = $clog2(MAX_BYTES + 1)
) (
  input  aux_op_e          op_i,
  input  logic [1:0]       phy_st_i,
  input  logic [7:0]       code_i,
  input  logic [LENW-1:0]  rx_len_i,
  output aux_act_e         act_o,
  output aux_status_e      status_o
);
  logic [1:0] nat, i2c;
  logic       native_op;

  assign nat       = code_i[5:4];
  assign i2c       = code_i[7:6];
  assign native_op = (op_i == OP_NAT_WR) || (op_i == OP_NAT_RD);

  always_comb begin
    act_o    = ACT_FINISH;
    status_o = ST_OK;
    case (phy_st_i)
      PHY_TIMEOUT: status_o = ST_TIMEOUT;
      PHY_ERROR:   status_o = ST_IO_ERR;
      PHY_BUSY:    act_o    = ACT_RETRY_NOW;
      default: begin
        if (nat == RPL_DEFER) act_o = ACT_RETRY_WAIT;
        else if (native_op) begin
          if (nat != RPL_ACK) begin
            if (op_i == OP_NAT_RD && rx_len_i == '0) status_o = ST_PROTO_ERR;
            else if (nat == RPL_NACK)               status_o = ST_NACK;
            else                                    status_o = ST_INVALID;
          end
        end else if (nat == RPL_NACK) status_o = ST_NACK;
        else if (nat != RPL_ACK)      status_o = ST_INVALID;
        else begin
          // I2C field only counts under a native ACK
          case (i2c)
            RPL_ACK:   status_o = ST_OK;
            RPL_NACK:  status_o = ST_NACK;
            RPL_DEFER: act_o    = ACT_RETRY_WAIT;
            default:   status_o = ST_INVALID;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int WAIT_CYC = 40000,
  localparam int CW = $clog2(WAIT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(WAIT_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  AST_LOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o); // R7
endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine
  import aux_req_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int DEFER_US  = 400,
  parameter int MAX_TRIES = 4,
  parameter int MAX_BYTES = 16,
  localparam int LENW     = $clog2(MAX_BYTES + 1),
  localparam int LW       = $clog2(MAX_BYTES + 5),
  localparam int TW       = $clog2(MAX_TRIES + 1),
  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * DEFER_US
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [2:0]             op_i,
  input  logic                   i2c_stop_i,
  input  logic [15:0]            addr_i,
  input  logic [LENW-1:0]        len_i,
  input  logic [MAX_BYTES*8-1:0] wdata_i,
  output logic                   tx_valid_o,
  input  logic                   tx_ready_i,
  output logic [7:0]             tx_data_o,
  output logic                   tx_last_o,
  input  logic                   rx_valid_i,
  input  logic [1:0]             rx_phy_st_i,
  input  logic [7:0]             rx_code_i,
  input  logic [LENW-1:0]        rx_len_i,
  input  logic [MAX_BYTES*8-1:0] rx_data_i,
  output logic                   done_o,
  output logic [2:0]             status_o,
  output logic [LENW-1:0]        rcv_len_o,
  output logic [MAX_BYTES*8-1:0] rdata_o
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT_RX, S_DELAY} state_e;

  state_e                 state_q;
  aux_op_e                op_q;
  logic                   stop_q;
  logic [15:0]            addr_q;
  logic [LENW-1:0]        len_q;
  logic [MAX_BYTES*8-1:0] wdata_q, rdata_q;
  logic [LW-1:0]          idx_q, nbytes;
  logic [TW-1:0]          tries_q, tries_nxt;
  logic                   done_q;
  aux_status_e            status_q, dec_status;
  aux_act_e               dec_act;
  logic [LENW-1:0]        rlen_q, cap, clamp;
  logic                   reject, budget_out, tmr_load, tmr_busy;

  assign reject = ((op_i == 3'd0) || (op_i == 3'd1)) &&
                  ((len_i == '0) || (len_i > LENW'(MAX_BYTES)));

  aux_hdr_build #(.MAX_BYTES(MAX_BYTES)) u_hdr (
    .op_i(op_q), .stop_i(stop_q), .addr_i(addr_q), .len_i(len_q),
    .wdata_i(wdata_q), .idx_i(idx_q), .byte_o(tx_data_o), .nbytes_o(nbytes)
  );

  aux_reply_decode #(.MAX_BYTES(MAX_BYTES)) u_dec (
    .op_i(op_q), .phy_st_i(rx_phy_st_i), .code_i(rx_code_i), .rx_len_i(rx_len_i),
    .act_o(dec_act), .status_o(dec_status)
  );

  aux_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .busy_o(tmr_busy)
  );

  assign tries_nxt  = tries_q + TW'(1);
  assign budget_out = (tries_nxt == TW'(MAX_TRIES));
  assign tmr_load   = (state_q == S_WAIT_RX) && rx_valid_i &&
                      (dec_act == ACT_RETRY_WAIT) && !budget_out;

  always_comb begin
    if (op_q == OP_NAT_RD)      cap = len_q;
    else if (op_q == OP_I2C_RD) cap = LENW'(1);
    else                        cap = '0;
    clamp = (rx_len_i > cap) ? cap : rx_len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= OP_NAT_WR;
      stop_q   <= 1'b0;
      addr_q   <= '0;
      len_q    <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      idx_q    <= '0;
      tries_q  <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
      rlen_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          op_q    <= aux_op_e'(op_i);
          stop_q  <= i2c_stop_i;
          addr_q  <= addr_i;
          len_q   <= len_i;
          wdata_q <= wdata_i;
          idx_q   <= '0;
          tries_q <= '0;
          if (reject) begin
            done_q   <= 1'b1;
            status_q <= ST_IO_ERR;
            rlen_q   <= '0;
          end else begin
            state_q <= S_SEND;
          end
        end
        S_SEND: if (tx_ready_i) begin
          if (idx_q == nbytes - LW'(1)) state_q <= S_WAIT_RX;
          else                          idx_q   <= idx_q + LW'(1);
        end
        S_WAIT_RX: if (rx_valid_i) begin
          tries_q <= tries_nxt;
          idx_q   <= '0;
          if (dec_act == ACT_FINISH) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= dec_status;
            rlen_q   <= (dec_status == ST_OK) ? clamp : '0;
            rdata_q  <= rx_data_i;
          end else if (budget_out) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
            status_q <= ST_IO_ERR;
            rlen_q   <= '0;
          end else if (dec_act == ACT_RETRY_NOW) begin
            state_q <= S_SEND;
          end else begin
            state_q <= S_DELAY;
          end
        end
        default: if (!tmr_busy) begin
          state_q <= S_SEND;
          idx_q   <= '0;
        end
      endcase
    end
  end

  assign tx_valid_o = (state_q == S_SEND);
  assign tx_last_o  = tx_valid_o && (idx_q == nbytes - LW'(1));
  assign done_o     = done_q;
  assign status_o   = status_q;
  assign rcv_len_o  = rlen_q;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_rmask
    assign rdata_o[k*8 +: 8] = (LENW'(k) < rlen_q) ? rdata_q[k*8 +: 8] : 8'h00;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_TRIES_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q <= TW'(MAX_TRIES)); // R8
  AST_NO_TX_IN_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_busy |-> !tx_valid_o); // R7
  AST_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && reject) |=> (done_o && status_o == 3'd3 && !tx_valid_o)); // R4
  AST_BUSY_RESEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT_RX && rx_valid_i && rx_phy_st_i == PHY_BUSY && !budget_out) |=> tx_valid_o); // R6
  AST_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_NAT_RD) |-> rcv_len_o <= len_q); // R11
endmodule

// File: tb/aux_req_engine_test.sv
module aux_req_engine_test;
  localparam int WAIT = 400;
  localparam logic [2:0] NW = 3'd0, NR = 3'd1, IW = 3'd2, IR = 3'd3, IA = 3'd4;
  localparam logic [2:0] S_OK = 3'd0, S_TO = 3'd1, S_NK = 3'd2, S_IO = 3'd3, S_PR = 3'd4, S_IV = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic        stp;
    logic [15:0] ad;
    logic [4:0]  ln;
    logic [15:0] r0, r1, r2, r3;  // {phy[1:0], 1'b0, rxlen[4:0], code[7:0]}
    logic [2:0]  est;
    logic [2:0]  eatt;
    logic [7:0]  eb2, eb3;
    logic [4:0]  erl;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{NW,1'b1,16'h1234,5'd3, 16'h0000,16'h0,16'h0,16'h0, S_OK,3'd1,8'h80,8'h72,5'd0,4'd1},  // R1
    '{NR,1'b1,16'h0000,5'd8, 16'h0800,16'h0,16'h0,16'h0, S_OK,3'd1,8'h90,8'h47,5'd8,4'd1},  // R1
    '{NR,1'b1,16'h0202,5'd2, 16'h0600,16'h0,16'h0,16'h0, S_OK,3'd1,8'h90,8'h41,5'd2,4'd11}, // R11
    '{NW,1'b1,16'h0103,5'd16,16'h0000,16'h0,16'h0,16'h0, S_OK,3'd1,8'h80,8'h4F,5'd0,4'd1},  // R1
    '{IW,1'b1,16'h0050,5'd1, 16'h0000,16'h0,16'h0,16'h0, S_OK,3'd1,8'h00,8'h50,5'd0,4'd1},  // R1
    '{IR,1'b0,16'h0050,5'd1, 16'h0300,16'h0,16'h0,16'h0, S_OK,3'd1,8'h50,8'h40,5'd1,4'd2},  // R2
    '{IA,1'b0,16'h0050,5'd0, 16'h0000,16'h0,16'h0,16'h0, S_OK,3'd1,8'h40,8'h30,5'd0,4'd3},  // R3
    '{IA,1'b1,16'h0051,5'd0, 16'h0000,16'h0,16'h0,16'h0, S_OK,3'd1,8'h00,8'h30,5'd0,4'd3},  // R3
    '{NR,1'b1,16'h0000,5'd1, 16'h4000,16'h0,16'h0,16'h0, S_TO,3'd1,8'h90,8'h40,5'd0,4'd5},  // R5
    '{NR,1'b1,16'h0000,5'd1, 16'hC000,16'h0,16'h0,16'h0, S_IO,3'd1,8'h90,8'h40,5'd0,4'd5},  // R5
    '{NR,1'b1,16'h0010,5'd4, 16'h8000,16'h0400,16'h0,16'h0, S_OK,3'd2,8'h90,8'h43,5'd4,4'd6}, // R6
    '{NW,1'b1,16'h0100,5'd1, 16'h0020,16'h0000,16'h0,16'h0, S_OK,3'd2,8'h80,8'h50,5'd0,4'd7}, // R7
    '{IR,1'b1,16'h0050,5'd0, 16'h0080,16'h0100,16'h0,16'h0, S_OK,3'd2,8'h10,8'h40,5'd1,4'd7}, // R7
    '{NR,1'b1,16'h0000,5'd1, 16'h8000,16'h8000,16'h8000,16'h8000, S_IO,3'd4,8'h90,8'h40,5'd0,4'd8}, // R8
    '{IW,1'b1,16'h0050,5'd0, 16'h0020,16'h8000,16'h0080,16'h0020, S_IO,3'd4,8'h00,8'h50,5'd0,4'd8}, // R8
    '{NW,1'b1,16'h0200,5'd2, 16'h0010,16'h0,16'h0,16'h0, S_NK,3'd1,8'h80,8'h61,5'd0,4'd9},  // R9
    '{NR,1'b1,16'h0200,5'd2, 16'h0010,16'h0,16'h0,16'h0, S_PR,3'd1,8'h90,8'h41,5'd0,4'd9},  // R9
    '{NR,1'b1,16'h0200,5'd2, 16'h0210,16'h0,16'h0,16'h0, S_NK,3'd1,8'h90,8'h41,5'd0,4'd9},  // R9
    '{IW,1'b1,16'h0050,5'd0, 16'h0060,16'h0000,16'h0,16'h0, S_OK,3'd2,8'h00,8'h50,5'd0,4'd9}, // R9
    '{IR,1'b1,16'h0050,5'd0, 16'h0040,16'h0,16'h0,16'h0, S_NK,3'd1,8'h10,8'h40,5'd0,4'd10}, // R10
    '{NW,1'b1,16'h0300,5'd1, 16'h0030,16'h0,16'h0,16'h0, S_IV,3'd1,8'h80,8'h50,5'd0,4'd10}, // R10
    '{IR,1'b1,16'h0050,5'd0, 16'h00C0,16'h0,16'h0,16'h0, S_IV,3'd1,8'h10,8'h40,5'd0,4'd10}, // R10
    '{NR,1'b1,16'h0000,5'd16,16'h1000,16'h0,16'h0,16'h0, S_OK,3'd1,8'h90,8'h4F,5'd16,4'd11} // R11
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, i2c_stop_i = 1'b0, tx_ready_i = 1'b1, rx_valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [15:0] addr_i = '0;
  logic [4:0] len_i = '0, rx_len_i = '0, rcv_len_o;
  logic [127:0] wdata_i, rx_data_i, rdata_o;
  logic [1:0] rx_phy_st_i = '0;
  logic [7:0] rx_code_i = '0, tx_data_o;
  logic tx_valid_o, tx_last_o, done_o;
  logic [2:0] status_o;

  int n_chk = 0, n_bad = 0;
  int r_att, r_nb, r_done_cyc, r_busy_max, r_wait_min, r_nbusy, r_nwait;
  logic [2:0] r_st;
  logic [4:0] r_rlen;
  logic [127:0] r_rdata;
  logic [7:0] hb [20];
  logic r_after;

  always #5 clk = ~clk;

  aux_req_engine #(.CLK_HZ(1_000_000), .DEFER_US(400)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_i(op_i), .i2c_stop_i(i2c_stop_i),
    .addr_i(addr_i), .len_i(len_i), .wdata_i(wdata_i), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o), .tx_last_o(tx_last_o),
    .rx_valid_i(rx_valid_i), .rx_phy_st_i(rx_phy_st_i), .rx_code_i(rx_code_i),
    .rx_len_i(rx_len_i), .rx_data_i(rx_data_i), .done_o(done_o), .status_o(status_o),
    .rcv_len_o(rcv_len_o), .rdata_o(rdata_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [2:0] op, input logic [15:0] rep);
    if (rep[15:14] == 2'd2) return 1;
    if (rep[15:14] != 2'd0) return 0;
    if (rep[5:4] == 2'd2) return 2;
    if (op >= IW && rep[5:4] == 2'd0 && rep[7:6] == 2'd2) return 2;
    return 0;
  endfunction

  task automatic run_req(input logic [2:0] op, input logic stp, input logic [15:0] ad,
                         input logic [4:0] ln, input logic [15:0] r0, input logic [15:0] r1,
                         input logic [15:0] r2, input logic [15:0] r3);
    logic [15:0] rep;
    bit fin = 0;
    int nb = 0, gap = 0, kind = 0;
    op_i = op; i2c_stop_i = stp; addr_i = ad; len_i = ln; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    r_att = 0; r_nb = 0; r_done_cyc = -1; r_busy_max = 0; r_wait_min = 1 << 30;
    r_nbusy = 0; r_nwait = 0; r_after = 1'b1;
    for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
      if (done_o) begin
        fin = 1; r_done_cyc = cyc; r_st = status_o; r_rlen = rcv_len_o; r_rdata = rdata_o;
      end else if (tx_valid_o) begin
        if (nb == 0 && r_att > 0) begin
          if (kind == 1) begin r_nbusy++; if (gap > r_busy_max) r_busy_max = gap; end
          if (kind == 2) begin r_nwait++; if (gap < r_wait_min) r_wait_min = gap; end
        end
        if (nb < 20) hb[nb] = tx_data_o;
        nb++;
        if (tx_last_o) begin
          r_nb = nb; nb = 0;
          @(negedge clk);
          case (r_att)
            0: rep = r0;
            1: rep = r1;
            2: rep = r2;
            default: rep = r3;
          endcase
          rx_phy_st_i = rep[15:14]; rx_len_i = rep[12:8]; rx_code_i = rep[7:0]; rx_valid_i = 1'b1;
          kind = kind_of(op, rep);
          @(negedge clk);
          rx_valid_i = 1'b0; r_att++; gap = 1;
          continue;
        end
      end else gap++;
      @(negedge clk);
    end
    chk("R12 request completes", int'(fin), 1);
    if (fin) begin
      @(negedge clk);
      r_after = done_o;
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      wdata_i[k*8 +: 8] = 8'h10 + 8'(k);
      rx_data_i[k*8 +: 8] = 8'hC0 + 8'(k);
    end
    repeat (3) @(negedge clk);
    chk("R12 reset done_o", int'(done_o), 0);
    chk("R12 reset tx_valid_o", int'(tx_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      string tg = $sformatf("R%0d v%0d", t.rq, v);
      int enb;
      run_req(t.op, t.stp, t.ad, t.ln, t.r0, t.r1, t.r2, t.r3);
      enb = (t.op == NW) ? 4 + int'(t.ln) : (t.op == IW) ? 5 : 4;
      chk({tg, " status"}, int'(r_st), int'(t.est));
      chk({tg, " attempts"}, r_att, int'(t.eatt));
      chk({tg, " R1 addr lo"}, int'(hb[0]), int'(t.ad[7:0]));
      chk({tg, " R1 addr hi"}, int'(hb[1]), int'(t.ad[15:8]));
      chk({tg, " cmd byte"}, int'(hb[2]), int'(t.eb2));
      chk({tg, " len byte"}, int'(hb[3]), int'(t.eb3));
      chk({tg, " R1 byte count"}, r_nb, enb);
      if (t.op == NW || t.op == IW) chk({tg, " R1 payload0"}, int'(hb[4]), 'h10);
      if (t.op == NW && t.ln == 5'd16) chk({tg, " R1 payload15"}, int'(hb[19]), 'h1F);
      chk({tg, " R11 rcv_len"}, int'(r_rlen), int'(t.erl));
      if (r_rlen != 0) chk({tg, " R11 rdata0"}, int'(r_rdata[7:0]), 'hC0);
      if (r_rlen < 16) chk({tg, " R11 masked byte"}, int'(r_rdata[r_rlen*8 +: 8]), 0);
      if (r_nbusy > 0) chk({tg, " R6 busy resend gap"}, int'(r_busy_max <= 2), 1);
      if (r_nwait > 0) chk({tg, " R7 defer pause"}, int'(r_wait_min >= WAIT), 1);
      chk({tg, " R12 done single pulse"}, int'(r_after), 0);
    end

    // R4: oversize native write and zero-length native read are rejected
    run_req(NW, 1'b1, 16'h0400, 5'd17, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R4 oversize status", int'(r_st), int'(S_IO));
    chk("R4 oversize no bytes", r_att + r_nb, 0);
    chk("R4 oversize latency", r_done_cyc, 0);
    run_req(NR, 1'b1, 16'h0400, 5'd0, 16'h0, 16'h0, 16'h0, 16'h0);
    chk("R4 zero len status", int'(r_st), int'(S_IO));
    chk("R4 zero len no bytes", r_att + r_nb, 0);
    // R8 budget restarts on the next request
    run_req(NR, 1'b1, 16'h0000, 5'd1, 16'h8000, 16'h8000, 16'h8000, 16'h0100);
    chk("R8 fourth attempt succeeds", int'(r_st), int'(S_OK));
    chk("R8 four attempts", r_att, 4);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R12 act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule